// File: doc/BRIEF.md
# Bitmap File Byte-Stream Formatter

This block turns a 24-bit RGB image held in an external synchronous memory into a complete, uncompressed bitmap file. It sends the file out one byte at a time, for example into a serial transmitter. A single start pulse latches the image width and height. The block then computes the padded row length, the pixel-array size and the total file size. It sends a 54-byte header (a 14-byte file header followed by a 40-byte info header) and then the pixel array.

The image memory is stored top line first: pixel (line, col) sits at address `line*width + col`. The memory returns the word one clock after the address. The file format wants the reverse arrangement, so the block walks the lines from the bottom up and sends each pixel blue first. It also appends zero bytes so that every row has a length that is a multiple of four.

The byte output uses a valid/ready handshake, so a slow consumer can stall the stream at any byte. When the last byte has been accepted, a done flag rises and stays high until the next start.

Top module: `bmp_stream_fmt`

## Requirements
- R1: While reset is applied, and right after it is released, `out_valid` and `done` are low.
- R2: The first 54 bytes form the header. All multi-byte fields are little-endian. The layout is:
  - 0x42 at offset 0 and 0x4D at offset 1;
  - 54 at offset 10 and 40 at offset 14;
  - width at offset 18 and height at offset 22;
  - 1 at offset 26 and 24 at offset 28;
  - every other byte outside the size fields is zero.
- R3: The 32-bit field at offset 2 holds the file size, 54 + P*H, where P = 3*W rounded up to a multiple of four. The field at offset 34 holds P*H.
- R4: Each pixel is sent as three bytes in the order `pix_data[7:0]` (blue), `pix_data[15:8]` (green), `pix_data[23:16]` (red).
- R5: Rows are sent bottom-up. The first row in the array is image line H-1, read from addresses `(H-1)*W + col`, and the last row is line 0.
- R6: Each row is followed by (4 - 3*W mod 4) mod 4 zero bytes.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` is unchanged. A byte counts as delivered only in a cycle with both signals high.
- R8: `done` rises in the cycle after the final byte is accepted. Exactly file-size bytes are delivered, and `out_valid` is low while `done` is high.
- R9: A start pulse during a transfer is ignored. The stream in progress completes unchanged.
- R10: If W or H is zero, only the 54 header bytes are sent, with a pixel-array size of 0 and a file size of 54.
- R11: A start pulse while idle or done begins a new file, and `done` falls in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a file; latches `img_w` and `img_h` |
| img_w | input | DIM_W | Image width in pixels |
| img_h | input | DIM_W | Image height in lines |
| pix_addr | output | ADDR_W | Pixel memory read address |
| pix_data | input | 24 | Pixel word returned one cycle after the address, {red, green, blue} |
| out_data | output | 8 | File byte |
| out_valid | output | 1 | `out_data` holds a byte |
| out_ready | input | 1 | Consumer accepts the byte this cycle |
| done | output | 1 | File complete; high until the next start |

## Verification
The bench sweeps every width from 1 to 6 against every height from 1 to 4. This covers all four padding amounts and both single-row and multi-row images. Any mistake in row order or pixel address shows up as a byte mismatch against a pixel value computed from its address.

Each run uses one of three consumer patterns: always ready, pseudo-random ready, and ready every third cycle. These separate correct stall handling from a design that only works at full rate.

Dedicated runs cover a zero width, a zero height and a start pulse during a transfer. Back-to-back files without an intervening reset exercise restarting from the done state.

// File: rtl/bmpfmt_pkg.sv
// Package: shared constants and sequencer states for the bitmap byte-stream formatter.
// Assumes the header layout is fixed: a 14-byte file header followed by a 40-byte info header.
package bmpfmt_pkg;
    localparam int HDR_BYTES = 54;
    localparam int INFO_BYTES = 40;
    localparam int BITS_PER_PX = 24;
    // byte offsets of the fields a file reader decodes
    localparam int OFS_FSIZE = 2;
    localparam int OFS_ARRAY = 10;
    localparam int OFS_INFO = 14;
    localparam int OFS_WIDTH = 18;
    localparam int OFS_HEIGHT = 22;
    localparam int OFS_PLANES = 26;
    localparam int OFS_DEPTH = 28;
    localparam int OFS_ASIZE = 34;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR,
        S_FETCH,
        S_LATCH,
        S_PIX,
        S_PAD,
        S_DONE
    } fmt_state_t;
endpackage

// File: rtl/bmp_geom.sv
// Module: derives the row padding, pixel-array size, file size and pixel count
// from the latched width and height. Purely combinational.
// Assumes the sizes fit in 32 bits and the pixel count fits in ADDR_W bits.
module bmp_geom #(
    parameter int DIM_W  = 12,
    parameter int ADDR_W = 2 * DIM_W
) (
    input  logic [DIM_W-1:0]  w,
    input  logic [DIM_W-1:0]  h,
    output logic [1:0]        pad,
    output logic [31:0]       arr_bytes,
    output logic [31:0]       file_bytes,
    output logic [ADDR_W-1:0] px_total
);
    import bmpfmt_pkg::*;

    logic [31:0] raw_row;
    logic [31:0] row_len;

    // Size arithmetic: the raw row, the pad up to a multiple of four, then the totals.
    always_comb begin
        raw_row    = 32'(w) * 32'd3;
        pad        = 2'd0 - raw_row[1:0];
        row_len    = raw_row + 32'(pad);
        arr_bytes  = row_len * 32'(h);
        file_bytes = arr_bytes + 32'(HDR_BYTES);
        px_total   = ADDR_W'(w) * ADDR_W'(h);
    end
endmodule

// File: rtl/bmp_hdr_byte.sv
// Module: selects header byte number idx (0..53) from the fixed header layout.
// Multi-byte fields are little-endian. Assumes idx < 54; any other offset yields zero.
module bmp_hdr_byte #(
    parameter int DIM_W = 12
) (
    input  logic [5:0]       idx,
    input  logic [DIM_W-1:0] w,
    input  logic [DIM_W-1:0] h,
    input  logic [31:0]      file_bytes,
    input  logic [31:0]      arr_bytes,
    output logic [7:0]       hbyte
);
    import bmpfmt_pkg::*;

    // Picks byte k of a 32-bit little-endian field.
    function automatic logic [7:0] le_byte(input logic [31:0] v, input int k);
        logic [31:0] s;
        s = v >> (8 * (k & 3));
        return s[7:0];
    endfunction

    int i;

    // Header byte mux: a range test per field, and zero everywhere else.
    always_comb begin
        i = int'(idx);
        hbyte = 8'h00;
        if (i == 0)
            hbyte = 8'h42;
        else if (i == 1)
            hbyte = 8'h4D;
        else if (i >= OFS_FSIZE && i < OFS_FSIZE + 4)
            hbyte = le_byte(file_bytes, i - OFS_FSIZE);
        else if (i >= OFS_ARRAY && i < OFS_ARRAY + 4)
            hbyte = le_byte(32'(HDR_BYTES), i - OFS_ARRAY);
        else if (i >= OFS_INFO && i < OFS_INFO + 4)
            hbyte = le_byte(32'(INFO_BYTES), i - OFS_INFO);
        else if (i >= OFS_WIDTH && i < OFS_WIDTH + 4)
            hbyte = le_byte(32'(w), i - OFS_WIDTH);
        else if (i >= OFS_HEIGHT && i < OFS_HEIGHT + 4)
            hbyte = le_byte(32'(h), i - OFS_HEIGHT);
        else if (i >= OFS_PLANES && i < OFS_PLANES + 2)
            hbyte = le_byte(32'd1, i - OFS_PLANES);
        else if (i >= OFS_DEPTH && i < OFS_DEPTH + 2)
            hbyte = le_byte(32'(BITS_PER_PX), i - OFS_DEPTH);
        else if (i >= OFS_ASIZE && i < OFS_ASIZE + 4)
            hbyte = le_byte(arr_bytes, i - OFS_ASIZE);
    end
endmodule

// File: rtl/bmp_stream_fmt.sv
// Module: top of the bitmap byte-stream formatter. It sends the header, then
// walks the image lines bottom-up. For each pixel it issues a read, captures the
// word and sends it blue, green, red; each row ends with zero padding.
// Assumes the memory returns pix_data one cycle after pix_addr and that
// width*height fits in ADDR_W bits.
module bmp_stream_fmt #(
    parameter int DIM_W  = 12,
    parameter int ADDR_W = 2 * DIM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIM_W-1:0]  img_w,
    input  logic [DIM_W-1:0]  img_h,
    output logic [ADDR_W-1:0] pix_addr,
    input  logic [23:0]       pix_data,
    output logic [7:0]        out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              done
);
    import bmpfmt_pkg::*;

    fmt_state_t        state;
    logic [DIM_W-1:0]  w_q, h_q;
    logic [DIM_W-1:0]  col, line;
    logic [ADDR_W-1:0] base;
    logic [5:0]        hidx;
    logic [1:0]        bsel, padcnt;
    logic [23:0]       pix_q;

    logic [1:0]        pad;
    logic [31:0]       arr_bytes, file_bytes;
    logic [ADDR_W-1:0] px_total;
    logic [7:0]        hbyte;
    logic              fire, row_end;

    bmp_geom #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_geom (
        .w(w_q), .h(h_q), .pad(pad), .arr_bytes(arr_bytes),
        .file_bytes(file_bytes), .px_total(px_total)
    );

    bmp_hdr_byte #(.DIM_W(DIM_W)) u_hdr (
        .idx(hidx), .w(w_q), .h(h_q), .file_bytes(file_bytes),
        .arr_bytes(arr_bytes), .hbyte(hbyte)
    );

    // Handshake and row-completion decode.
    always_comb begin
        fire    = out_valid && out_ready;
        row_end = fire && (((state == S_PIX) && (bsel == 2'd2) &&
                            (col == w_q - DIM_W'(1)) && (pad == 2'd0)) ||
                           ((state == S_PAD) && (padcnt == pad - 2'd1)));
    end

    // Output byte mux and status flags.
    always_comb begin
        out_valid = (state == S_HDR) || (state == S_PIX) || (state == S_PAD);
        done      = (state == S_DONE);
        pix_addr  = base + ADDR_W'(col);
        case (state)
            S_HDR: out_data = hbyte;
            S_PIX: case (bsel)
                2'd0:    out_data = pix_q[7:0];
                2'd1:    out_data = pix_q[15:8];
                default: out_data = pix_q[23:16];
            endcase
            default: out_data = 8'h00;
        endcase
    end

    // Sequencer: header, then per pixel a fetch, capture and three bytes, then row padding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            w_q    <= '0;
            h_q    <= '0;
            col    <= '0;
            line   <= '0;
            base   <= '0;
            hidx   <= '0;
            bsel   <= '0;
            padcnt <= '0;
            pix_q  <= '0;
        end else begin
            case (state)
                S_IDLE, S_DONE: if (start) begin
                    w_q   <= img_w;
                    h_q   <= img_h;
                    hidx  <= '0;
                    state <= S_HDR;
                end
                S_HDR: if (fire) begin
                    if (hidx == 6'(HDR_BYTES - 1)) begin
                        if ((w_q == '0) || (h_q == '0)) begin
                            state <= S_DONE;
                        end else begin
                            line  <= h_q - DIM_W'(1);
                            base  <= px_total - ADDR_W'(w_q);
                            col   <= '0;
                            state <= S_FETCH;
                        end
                    end else begin
                        hidx <= hidx + 6'd1;
                    end
                end
                S_FETCH: state <= S_LATCH;
                S_LATCH: begin
                    pix_q <= pix_data;
                    bsel  <= '0;
                    state <= S_PIX;
                end
                S_PIX: if (fire) begin
                    if (bsel == 2'd2) begin
                        if (col == w_q - DIM_W'(1)) begin
                            padcnt <= '0;
                            state  <= S_PAD;
                        end else begin
                            col   <= col + DIM_W'(1);
                            state <= S_FETCH;
                        end
                    end else begin
                        bsel <= bsel + 2'd1;
                    end
                end
                S_PAD: if (fire) padcnt <= padcnt + 2'd1;
                default: state <= S_IDLE;
            endcase
            // End of row: move up one image line, or finish after line 0.
            if (row_end) begin
                if (line == '0) begin
                    state <= S_DONE;
                end else begin
                    line  <= line - DIM_W'(1);
                    base  <= base - ADDR_W'(w_q);
                    col   <= '0;
                    state <= S_FETCH;
                end
            end
        end
    end
endmodule

// File: rtl/bmp_stream_chk.sv
// Module: protocol checker for the bitmap byte-stream formatter, attached by bind.
// Assumes only the top-level ports; looks at no internal state.
module bmp_stream_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [7:0] out_data,
    input logic       out_valid,
    input logic       out_ready,
    input logic       done
);
    // R7: a stalled byte stays offered and unchanged.
    assert_hold_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid);
    assert_hold_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> $stable(out_data));
    // R8: done never overlaps a byte offer and rises only after an accepted byte.
    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);
    assert_done_after_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(out_valid && out_ready));
    // R9: a start during a stalled transfer leaves the transfer running.
    assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && start |=> out_valid);
    // R11: a start while done begins a new file.
    assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done && start |=> !done && out_valid);
endmodule

bind bmp_stream_fmt bmp_stream_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .done(done)
);

// File: tb/sim_bmp_stream_fmt.sv
`timescale 1ns/1ps
// Bench: sweeps small image sizes and consumer patterns and compares every
// delivered byte with a value computed arithmetically.
module sim_bmp_stream_fmt;
    localparam int DIM_W = 12;
    localparam int ADDR_W = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [DIM_W-1:0]  img_w = '0, img_h = '0;
    logic [ADDR_W-1:0] pix_addr;
    logic [23:0]       pix_data = '0;
    logic [7:0]        out_data;
    logic              out_valid, out_ready = 1'b0, done;

    int nchk = 0, nerr = 0;
    int ready_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [23:0] mem [64];
    logic [7:0]  cap [256];
    int cap_n = 0, stall_err = 0;
    logic prev_v = 1'b0, prev_r = 1'b0;
    logic [7:0] prev_d = '0;

    bmp_stream_fmt #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .img_w(img_w), .img_h(img_h),
        .pix_addr(pix_addr), .pix_data(pix_data), .out_data(out_data),
        .out_valid(out_valid), .out_ready(out_ready), .done(done)
    );

    always #4 clk = ~clk;

    function automatic logic [23:0] pixel(int a);
        return {8'(a * 37 + 5), 8'(a * 11 + 100), 8'(a * 3 + 200)};
    endfunction
    function automatic int row_len(int w);
        return ((3 * w + 3) / 4) * 4;
    endfunction
    function automatic int fsize(int w, int h);
        return 54 + row_len(w) * h;
    endfunction
    function automatic logic [7:0] le(int v, int k);
        return 8'(v >> (8 * k));
    endfunction
    function automatic logic [7:0] hdr_exp(int w, int h, int k);
        if (k == 0) return 8'h42;
        if (k == 1) return 8'h4D;
        if (k >= 2 && k <= 5) return le(fsize(w, h), k - 2);
        if (k >= 10 && k <= 13) return le(54, k - 10);
        if (k >= 14 && k <= 17) return le(40, k - 14);
        if (k >= 18 && k <= 21) return le(w, k - 18);
        if (k >= 22 && k <= 25) return le(h, k - 22);
        if (k == 26) return 8'd1;
        if (k == 28) return 8'd24;
        if (k >= 34 && k <= 37) return le(row_len(w) * h, k - 34);
        return 8'h00;
    endfunction
    function automatic logic [7:0] pix_exp(int w, int h, int k);
        int off, r, c, ln;
        logic [23:0] p;
        off = k - 54;
        r = off / row_len(w);
        c = off % row_len(w);
        ln = h - 1 - r;
        if (c >= 3 * w) return 8'h00;
        p = pixel(ln * w + c / 3);
        case (c % 3)
            0: return p[7:0];
            1: return p[15:8];
            default: return p[23:16];
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Memory model: synchronous read with one cycle of latency.
    initial forever begin
        @(posedge clk);
        pix_data <= mem[pix_addr[5:0]];
    end

    // Consumer ready pattern, changed just after each rising edge.
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (ready_mode)
                0: out_ready = 1'b1;
                1: out_ready = lfsr[0];
                default: out_ready = (cyc % 3 == 0);
            endcase
        end
    end

    // Byte capture and stall monitor at the falling edge.
    initial forever begin
        @(negedge clk);
        if (prev_v && !prev_r && (!out_valid || out_data != prev_d)) stall_err++;
        if (out_valid && out_ready && cap_n < 256) begin
            cap[cap_n] = out_data;
            cap_n++;
        end
        prev_v = out_valid;
        prev_r = out_ready;
        prev_d = out_data;
    end

    task automatic run_file(int w, int h, int mode, bit poke);
        int t, exp_n, lim;
        int e_hdr, e_sz, e_px, e_pad;
        int a_hdr, x_hdr, a_sz, x_sz, a_px, x_px, a_pad, x_pad;
        e_hdr = 0; e_sz = 0; e_px = 0; e_pad = 0;
        a_hdr = 0; x_hdr = 0; a_sz = 0; x_sz = 0;
        a_px = 0; x_px = 0; a_pad = 0; x_pad = 0;
        ready_mode = mode;
        @(negedge clk);
        cap_n = 0;
        stall_err = 0;
        start = 1'b1;
        img_w = DIM_W'(w);
        img_h = DIM_W'(h);
        @(negedge clk);
        start = 1'b0;
        check(!done && out_valid, "R11 done falls after start", int'(done), 0);
        if (poke) begin
            repeat (20) @(negedge clk);
            start = 1'b1;
            img_w = DIM_W'(1);
            img_h = DIM_W'(1);
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        exp_n = fsize(w, h);
        lim = (cap_n < exp_n) ? cap_n : exp_n;
        for (int k = 0; k < lim; k++) begin
            logic [7:0] ex;
            if (k < 54) begin
                ex = hdr_exp(w, h, k);
                if ((k >= 2 && k <= 5) || (k >= 34 && k <= 37)) begin
                    if (cap[k] != ex && e_sz == 0) begin
                        e_sz = 1; a_sz = cap[k]; x_sz = ex;
                    end
                end else if (cap[k] != ex && e_hdr == 0) begin
                    e_hdr = 1; a_hdr = cap[k]; x_hdr = ex;
                end
            end else begin
                ex = pix_exp(w, h, k);
                if (((k - 54) % row_len(w)) >= 3 * w) begin
                    if (cap[k] != ex && e_pad == 0) begin
                        e_pad = 1; a_pad = cap[k]; x_pad = ex;
                    end
                end else if (cap[k] != ex && e_px == 0) begin
                    e_px = 1; a_px = cap[k]; x_px = ex;
                end
            end
        end
        check(e_hdr == 0, "R2 header byte", a_hdr, x_hdr);
        check(e_sz == 0, "R3 size field byte", a_sz, x_sz);
        if (w > 0 && h > 0) begin
            check(e_px == 0, "R4 R5 pixel byte order", a_px, x_px);
            check(e_pad == 0, "R6 row padding byte", a_pad, x_pad);
        end
        check(stall_err == 0, "R7 stalled byte changed", stall_err, 0);
        if (w == 0 || h == 0)
            check(done && cap_n == 54, "R10 header-only length", cap_n, 54);
        else
            check(done && cap_n == exp_n, "R8 bytes delivered at done", cap_n, exp_n);
        if (poke)
            check(cap_n == exp_n && e_px == 0 && e_hdr == 0 && e_sz == 0,
                  "R9 start during transfer ignored", cap_n, exp_n);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL R8 watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        for (int a = 0; a < 64; a++) mem[a] = pixel(a);
        repeat (3) @(negedge clk);
        check(!out_valid && !done, "R1 outputs low in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !done, "R1 outputs low after reset", int'(done), 0);
        for (int w = 1; w <= 6; w++)
            for (int h = 1; h <= 4; h++)
                run_file(w, h, (w + h) % 3, 1'b0);
        run_file(0, 3, 1, 1'b0);
        run_file(4, 0, 2, 1'b0);
        run_file(5, 3, 2, 1'b1);
        run_file(3, 2, 0, 1'b0);
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule